// File: doc/BRIEF.md
# Serial Result Readout Port for a Sampling Converter

This block is the device side of the serial result path of a successive-approximation converter. It holds the most recent 16-bit result. It shifts a word out on a single data pin, most significant bit first, and the host drives the shift clock. The host clock may stop between words and may run at any rate slower than the system clock. The host clock is brought into the system clock domain by a short synchronizer. All output changes happen on the system clock, after a rising host-clock edge is detected.

Conversions start when read/convert falls while the chip select is low. A counter stands in for the analog conversion. The busy output stays low for a fixed number of system clocks, and when it rises the value on the sample input becomes the new result. The host can read the previous result while busy is low, or the new result after busy rises. The chosen word is captured at the first shift edge, so a conversion that ends during a read does not disturb the word being sent.

Two bit alignments are supported. Without framing, the first rising host-clock edge of a read puts the MSB on the pin. If the host clock rose at least once while reads were disabled, a framing mode is armed. In that mode the first edge of the read raises a one-bit frame marker, and the MSB follows one edge later.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, data_out and sync_out are low and busy is high.
- R2: A falling edge of rd_conv with cs_n low, while busy is high, drives busy low for exactly CONV_CYCLES system clocks. When busy rises, the value of sample_in is stored as the new result.
- R3: A read started while busy is low shifts out the result of the previous, completed conversion.
- R4: A read started after busy has risen shifts out the result of the conversion that just finished.
- R5: In unframed mode, after the k-th rising host-clock edge of a read (k = 1..16), data_out carries bit 16-k of the word, so the MSB (bit 15) comes first. sync_out stays low.
- R6: Framed mode is armed by a rising host-clock edge seen while cs_n is high, or while cs_n and rd_conv are both low.
- R7: In framed mode, the first rising edge of the read drives sync_out high with data_out low. sync_out returns low at the second edge, so the marker lasts one host-clock period.
- R8: In framed mode, after rising edge k (k = 2..17), data_out carries bit 17-k of the word.
- R9: After the LSB, the next rising edge drives data_out low. data_out and sync_out then stay low through further edges until the read is disabled and enabled again.
- R10: While a read is not enabled (cs_n high, or rd_conv low), host-clock edges do not shift data: data_out and sync_out stay low, and the next read still starts from its first bit.
- R11: A further falling edge of rd_conv while busy is low does not restart or lengthen the conversion.
- R12: A framed read uses up the arming. A following read with no new arming edge is unframed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | High: read enabled; falling edge: start a conversion |
| dclk | input | 1 | Host-supplied shift clock, may stop between words |
| sample_in | input | WORD_W | Value taken as the conversion result when busy rises |
| data_out | output | 1 | Serial result, MSB first |
| sync_out | output | 1 | One-bit frame marker ahead of the MSB in framed mode |
| busy | output | 1 | Low while a conversion runs |

## Verification
Most faults in the read state machine show up at the pins within one host-clock period. A wrong arming flag or sequencer state puts the frame marker where the MSB should be, or the reverse, on the first edge of the next read. A bit counter off by one either sends a seventeenth bit or drops the low level after the LSB within the same word. A wrong conversion counter shows in the busy width on the very next conversion. A result register loaded at the wrong time only shows on the next read, as the wrong word. The bench therefore reads both the previous and the current word around every conversion.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    localparam int WORD_W_DEF      = 16;
    localparam int CONV_CYCLES_DEF = 40;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_MARK,
        RD_SHIFT,
        RD_DONE
    } rd_state_e;

    typedef struct packed {
        logic data;
        logic mark;
    } pin_drive_t;

    localparam pin_drive_t PINS_QUIET = '{data: 1'b0, mark: 1'b0};

    function automatic logic read_enabled(input logic cs_n, input logic rd_conv);
        return !cs_n && rd_conv;
    endfunction

    function automatic logic arm_window(input logic cs_n, input logic rd_conv);
        return cs_n || !rd_conv;
    endfunction

    function automatic logic conv_request(input logic cs_n, input logic rd_conv,
                                          input logic rd_conv_q);
        return !cs_n && !rd_conv && rd_conv_q;
    endfunction

endpackage

// File: rtl/adc_dclk_edge.sv
module adc_dclk_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dclk_in,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], dclk_in};
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int WORD_W      = 16,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] sample_in,
    output logic              busy,
    output logic [WORD_W-1:0] result
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b1;
            remain <= '0;
            result <= '0;
        end else if (busy) begin
            if (start) begin
                busy   <= 1'b0;
                remain <= CNT_W'(CONV_CYCLES - 1);
            end
        end else if (remain == '0) begin
            busy   <= 1'b1;
            result <= sample_in;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out
    import adc_port_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              rd_en,
    input  logic              arm_win,
    input  logic [WORD_W-1:0] word,
    output logic              data_out,
    output logic              sync_out
);
    localparam int CW = $clog2(WORD_W + 1);

    rd_state_e         state;
    logic              armed;
    logic [WORD_W-1:0] shreg;
    logic [CW-1:0]     sent;
    pin_drive_t        pins;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
            armed <= 1'b0;
            shreg <= '0;
            sent  <= '0;
            pins  <= PINS_QUIET;
        end else begin
            if (rise && arm_win) begin
                armed <= 1'b1;
            end
            if (!rd_en) begin
                state <= RD_IDLE;
                sent  <= '0;
                pins  <= PINS_QUIET;
            end else if (rise) begin
                case (state)
                    RD_IDLE: begin
                        if (armed) begin
                            armed <= 1'b0;
                            shreg <= word;
                            pins  <= '{data: 1'b0, mark: 1'b1};
                            state <= RD_MARK;
                        end else begin
                            shreg <= word << 1;
                            sent  <= CW'(1);
                            pins  <= '{data: word[WORD_W-1], mark: 1'b0};
                            state <= RD_SHIFT;
                        end
                    end
                    RD_MARK: begin
                        shreg <= shreg << 1;
                        sent  <= CW'(1);
                        pins  <= '{data: shreg[WORD_W-1], mark: 1'b0};
                        state <= RD_SHIFT;
                    end
                    RD_SHIFT: begin
                        if (sent == CW'(WORD_W)) begin
                            pins  <= PINS_QUIET;
                            state <= RD_DONE;
                        end else begin
                            shreg <= shreg << 1;
                            sent  <= sent + 1'b1;
                            pins  <= '{data: shreg[WORD_W-1], mark: 1'b0};
                        end
                    end
                    default: begin
                        pins <= PINS_QUIET;
                    end
                endcase
            end
        end
    end

    assign data_out = pins.data;
    assign sync_out = pins.mark;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int WORD_W      = WORD_W_DEF,
    parameter int CONV_CYCLES = CONV_CYCLES_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_conv,
    input  logic              dclk,
    input  logic [WORD_W-1:0] sample_in,
    output logic              data_out,
    output logic              sync_out,
    output logic              busy
);
    logic              rd_conv_q;
    logic              dclk_rise;
    logic              conv_start;
    logic [WORD_W-1:0] result;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_conv_q <= 1'b1;
        end else begin
            rd_conv_q <= rd_conv;
        end
    end

    assign conv_start = conv_request(cs_n, rd_conv, rd_conv_q);

    adc_dclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .dclk_in (dclk),
        .rise    (dclk_rise)
    );

    adc_conv_timer #(.WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (conv_start),
        .sample_in (sample_in),
        .busy      (busy),
        .result    (result)
    );

    adc_shift_out #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .rise     (dclk_rise),
        .rd_en    (read_enabled(cs_n, rd_conv)),
        .arm_win  (arm_window(cs_n, rd_conv)),
        .word     (result),
        .data_out (data_out),
        .sync_out (sync_out)
    );
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
    parameter int CONV_CYCLES = 40
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic rd_conv,
    input logic data_out,
    input logic sync_out,
    input logic busy,
    input logic dclk_rise
);
    int unsigned low_cycles;

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            low_cycles <= 0;
        end else begin
            low_cycles <= low_cycles + 1;
        end
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> low_cycles == CONV_CYCLES); // R2
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(!cs_n && !rd_conv)); // R2
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !rd_conv) |=> (!data_out && !sync_out)); // R10
    AST_MARK_ALONE: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> !data_out); // R7
    AST_MARK_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> $past(dclk_rise)); // R7
    AST_DATA_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_out) |-> ($past(dclk_rise) || $past(cs_n || !rd_conv))); // R5
endmodule

bind adc_serial_port adc_serial_port_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_conv   (rd_conv),
    .data_out  (data_out),
    .sync_out  (sync_out),
    .busy      (busy),
    .dclk_rise (dclk_rise)
);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
    localparam int W    = 16;
    localparam int CONV = 40;

    // vector: [17:2] word, [1] framed, [0] read during conversion
    localparam logic [17:0] VECS [0:3] = '{
        {16'hA5C3, 1'b0, 1'b0},
        {16'h8001, 1'b1, 1'b0},
        {16'h7FFE, 1'b0, 1'b1},
        {16'h3C96, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst, cs_n, rd_conv, dclk;
    logic [W-1:0] sample_in;
    logic data_out, sync_out, busy;
    int checks = 0;
    int fails  = 0;
    logic [W-1:0] last;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_serial_port #(.WORD_W(W), .CONV_CYCLES(CONV)) i_adc_serial_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_conv(rd_conv), .dclk(dclk),
        .sample_in(sample_in), .data_out(data_out), .sync_out(sync_out), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) dclk = 1'b1;
        repeat (4) @(negedge clk);
        dclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_word(input logic [W-1:0] exp, input bit framed, input string req);
        int n = framed ? 18 : 17;
        for (int k = 1; k <= n; k++) begin
            logic ed, es;
            pulse();
            if (framed) begin
                es = (k == 1);
                ed = (k >= 2 && k <= 17) ? exp[17-k] : 1'b0;
            end else begin
                es = 1'b0;
                ed = (k <= 16) ? exp[16-k] : 1'b0;
            end
            check($sformatf("%s data edge %0d", req, k), int'(data_out), int'(ed));
            check($sformatf("%s sync edge %0d", req, k), int'(sync_out), int'(es));
        end
    endtask

    task automatic start_conv(input logic [W-1:0] val, input bit arm);
        @(negedge clk) sample_in = val;
        cs_n = 1'b0;
        rd_conv = 1'b0;
        repeat (2) @(negedge clk);
        if (arm) pulse();
        rd_conv = 1'b1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && busy == 1'b0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int lowcnt;
        rst = 1'b1; cs_n = 1'b1; rd_conv = 1'b1; dclk = 1'b0; sample_in = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 data", int'(data_out), 0);
        check("R1 sync", int'(sync_out), 0);
        check("R1 busy", int'(busy), 1);

        // R2 busy width, R11 second request ignored
        sample_in = 16'h1234;
        cs_n = 1'b0;
        rd_conv = 1'b0;
        lowcnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (i == 5) rd_conv = 1'b1;
            if (i == 7) rd_conv = 1'b0;
            if (busy == 1'b0) lowcnt++;
            else if (lowcnt > 0) break;
        end
        check("R2/R11 busy low cycles", lowcnt, CONV);
        rd_conv = 1'b1;
        repeat (3) @(negedge clk);
        read_word(16'h1234, 1'b0, "R4/R5 after conversion");
        last = 16'h1234;

        for (int v = 0; v < 4; v++) begin
            logic [W-1:0] w = VECS[v][17:2];
            bit framed = VECS[v][1];
            bit during = VECS[v][0];
            start_conv(w, framed);
            if (during) begin
                check("R3 busy low at read", int'(busy), 0);
                read_word(last, framed, framed ? "R3/R8 previous framed" : "R3/R5 previous");
                wait_ready();
            end else begin
                wait_ready();
                read_word(w, framed, framed ? "R4/R7/R8 current framed" : "R4/R5 current");
            end
            last = w;
        end

        // R10 edges while disabled shift nothing; R6 they arm framing
        @(negedge clk) cs_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            pulse();
            check("R10 data while disabled", int'(data_out), 0);
            check("R10 sync while disabled", int'(sync_out), 0);
        end
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        read_word(last, 1'b1, "R6 armed by cs high");
        // R9 quiet after the LSB
        for (int i = 0; i < 3; i++) begin
            pulse();
            check("R9 data after lsb", int'(data_out), 0);
            check("R9 sync after lsb", int'(sync_out), 0);
        end
        // R12 arming consumed
        @(negedge clk) cs_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        read_word(last, 1'b0, "R12 unframed after use");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule